// File: doc/BRIEF.md
# Bidirectional Row-Scan Shift Register

This block is the logic core of a row-select driver for an active-matrix panel. A start pulse presented on one end pin is captured on a rising clock edge. It then steps across a row of scan outputs, one position per rising edge. When it has passed the last output, it leaves the block as a one-clock cascade pulse on the opposite end pin, ready to start a following device.

A direction input decides which end pin listens and which one drives, and so also the order in which the outputs are visited. A polarity input sets whether the start and cascade pulses are active high or active low. Two enable inputs override the scan outputs without touching the register contents: one blanks every output low and the other floods every output high. Each enable has its own polarity select, and blanking wins over flooding. The outputs are plain logic levels. Each end pin is modelled as a separate input, output and output-enable.

Top module: `gate_scan_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, every register stage is cleared. At the next falling edge the cascade pin goes to its inactive level. With no override active, all scan outputs then read 0.
- R2: With `dir_fwd` = 1, a start pulse on `end_a_in` that is captured at a rising edge appears on `scan_o[0]`. Each later rising edge moves every pulse from `scan_o[i]` to `scan_o[i+1]`, and a pulse leaves the block after `scan_o[N_OUT-1]`.
- R3: With `dir_fwd` = 0, a start pulse on `end_b_in` enters at `scan_o[N_OUT-1]`. Each rising edge moves every pulse from `scan_o[i]` to `scan_o[i-1]`, and a pulse leaves the block after `scan_o[0]`.
- R4: A start pin counts as active when its level equals `start_pol` (1 = active high, 0 = active low). Only the pin that serves as the start input for the current direction is sampled.
- R5: The cascade pin shows the active `start_pol` level from the falling edge that follows the rising edge which loads the last output in scan order. It returns to the inactive level at the next falling edge. A pulse captured at rising edge 1 is therefore active from falling edge N_OUT to falling edge N_OUT+1. Output overrides do not affect the cascade pin.
- R6: `end_b_oe` = 1 and `end_a_oe` = 0 when `dir_fwd` = 1. `end_a_oe` = 1 and `end_b_oe` = 0 when `dir_fwd` = 0. The driven pin carries the cascade level.
- R7: While `blank_en` equals `blank_pol`, every scan output is 0 at once, with no clock edge needed. When the enable is released, the outputs show the register contents, which have kept shifting in the meantime.
- R8: While `flood_en` equals `flood_pol` and blanking is inactive, every scan output is 1 at once, with no clock edge needed. The register contents are kept.
- R9: `blank_pol` and `flood_pol` each select the active level of their enable (1 = active high, 0 = active low).
- R10: When both overrides are active, every scan output is 0.
- R11: A register stage that holds a pulse shows as 1 on its unforced scan output, whatever the value of `start_pol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; shifts on the rising edge, cascade updates on the falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_fwd | input | 1 | 1: end A starts, outputs visited upward, end B cascades; 0: reverse |
| start_pol | input | 1 | Active level of the start and cascade pulses |
| blank_en | input | 1 | Force-low enable |
| blank_pol | input | 1 | Active level of `blank_en` |
| flood_en | input | 1 | Force-high enable |
| flood_pol | input | 1 | Active level of `flood_en` |
| end_a_in | input | 1 | End A pin, input side |
| end_a_out | output | 1 | End A pin, output side |
| end_a_oe | output | 1 | End A output enable |
| end_b_in | input | 1 | End B pin, input side |
| end_b_out | output | 1 | End B pin, output side |
| end_b_oe | output | 1 | End B output enable |
| scan_o | output | N_OUT | Scan outputs, index 0 is the first output when `dir_fwd` = 1 |

## Verification
The bench builds the block with its default `N_OUT` = 240. This lets a single pulse be followed along the whole row, so the cascade timing at the 240th and 241st falling edges can be observed directly, in both directions and for both start polarities. At this width the bench can also keep two pulses in flight at once and reverse the direction while a pulse is mid-row. It can hold an override long enough for the register to move several positions underneath it, so that the release shows the contents were kept.

// File: rtl/gate_scan_pkg.sv
// Package: shared types and helpers for the row-scan shift register.
// Assumes: polarity selects are 1 for active-high, 0 for active-low.
package gate_scan_pkg;

    typedef enum logic {
        SCAN_REV = 1'b0,
        SCAN_FWD = 1'b1
    } scan_dir_e;

    // True when a pin sits at the level its polarity select calls active.
    function automatic logic lvl_active(input logic pin, input logic pol);
        return (pin == pol);
    endfunction

    // Pin level that expresses a logical pulse under a given polarity.
    function automatic logic lvl_drive(input logic pulse, input logic pol);
        return pol ? pulse : ~pulse;
    endfunction

endpackage

// File: rtl/gate_scan_shifter.sv
// Module: gate_scan_shifter
// The bidirectional pulse register. Each stage loads from its lower
// neighbour when shifting forward and from its upper neighbour when
// shifting in reverse. The start bit enters at stage 0 or at stage N-1.
// Assumes: start_hit is already decoded to active-high.
module gate_scan_shifter
    import gate_scan_pkg::*;
#(
    parameter int N_OUT = 240
) (
    input  logic             clk,
    input  logic             rst_n,
    input  scan_dir_e        dir,
    input  logic             start_hit,
    output logic [N_OUT-1:0] stage
);

    localparam int LAST = N_OUT - 1;

    logic [N_OUT-1:0] stage_nxt;

    // Next-state of every stage, picked per position by direction.
    for (genvar i = 0; i < N_OUT; i++) begin : g_stage
        logic from_low;
        logic from_high;
        if (i == 0) begin : g_first
            assign from_low = start_hit;
        end else begin : g_mid_lo
            assign from_low = stage[i-1];
        end
        if (i == LAST) begin : g_last
            assign from_high = start_hit;
        end else begin : g_mid_hi
            assign from_high = stage[i+1];
        end
        always_comb begin
            // choose the neighbour that feeds this stage
            stage_nxt[i] = (dir == SCAN_FWD) ? from_low : from_high;
        end
    end

    // Register update on the rising edge; synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stage <= '0;
        else        stage <= stage_nxt;
    end

endmodule

// File: rtl/gate_scan_ends.sv
// Module: gate_scan_ends
// Handles both end pins. It decodes the start input on the listening pin
// and retimes the far-end stage onto the falling edge to form the cascade
// pulse, which it drives onto the pin facing away from the start.
// Assumes: the cascade pulse lasts from one falling edge to the next.
module gate_scan_ends
    import gate_scan_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  scan_dir_e dir,
    input  logic      start_pol,
    input  logic      tail_fwd,
    input  logic      tail_rev,
    input  logic      end_a_in,
    input  logic      end_b_in,
    output logic      start_hit,
    output logic      end_a_out,
    output logic      end_a_oe,
    output logic      end_b_out,
    output logic      end_b_oe
);

    logic casc_q;
    logic casc_lvl;

    // Decode the start level on the pin that listens in this direction.
    always_comb begin
        start_hit = (dir == SCAN_FWD) ? lvl_active(end_a_in, start_pol)
                                      : lvl_active(end_b_in, start_pol);
    end

    // Falling-edge copy of the stage that exits in this direction.
    always_ff @(negedge clk) begin
        if (!rst_n) casc_q <= 1'b0;
        else        casc_q <= (dir == SCAN_FWD) ? tail_fwd : tail_rev;
    end

    // Express the cascade pulse at the selected level and steer the enables.
    always_comb begin
        casc_lvl  = lvl_drive(casc_q, start_pol);
        end_a_out = casc_lvl;
        end_b_out = casc_lvl;
        end_a_oe  = (dir == SCAN_REV);
        end_b_oe  = (dir == SCAN_FWD);
    end

endmodule

// File: rtl/gate_scan_override.sv
// Module: gate_scan_override
// Purely combinational output stage. The force-low and force-high
// enables act with no clock, and force-low wins. The register is
// never touched from here.
// Assumes: each enable is compared against its own polarity select.
module gate_scan_override
    import gate_scan_pkg::*;
#(
    parameter int N_OUT = 240
) (
    input  logic [N_OUT-1:0] stage,
    input  logic             blank_en,
    input  logic             blank_pol,
    input  logic             flood_en,
    input  logic             flood_pol,
    output logic [N_OUT-1:0] scan_o
);

    logic blank_act;
    logic flood_act;

    // Resolve the enable levels once for all outputs.
    always_comb begin
        blank_act = lvl_active(blank_en, blank_pol);
        flood_act = lvl_active(flood_en, flood_pol);
    end

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        // per-output forcing with force-low priority
        always_comb begin
            if (blank_act)      scan_o[i] = 1'b0;
            else if (flood_act) scan_o[i] = 1'b1;
            else                scan_o[i] = stage[i];
        end
    end

endmodule

// File: rtl/gate_scan_core.sv
// Module: gate_scan_core (top)
// Row-scan shift register with direction-switchable end pins, a start
// pulse of selectable polarity and two clock-free output overrides.
// Assumes: a single clock; reset is synchronous and active low.
module gate_scan_core
    import gate_scan_pkg::*;
#(
    parameter int N_OUT = 240
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_fwd,
    input  logic             start_pol,
    input  logic             blank_en,
    input  logic             blank_pol,
    input  logic             flood_en,
    input  logic             flood_pol,
    input  logic             end_a_in,
    output logic             end_a_out,
    output logic             end_a_oe,
    input  logic             end_b_in,
    output logic             end_b_out,
    output logic             end_b_oe,
    output logic [N_OUT-1:0] scan_o
);

    localparam int LAST = N_OUT - 1;

    scan_dir_e        dir;
    logic             start_hit;
    logic [N_OUT-1:0] stage;

    // Map the raw direction pin onto the shared enum.
    always_comb begin
        dir = dir_fwd ? SCAN_FWD : SCAN_REV;
    end

    gate_scan_ends u_ends (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir       (dir),
        .start_pol (start_pol),
        .tail_fwd  (stage[LAST]),
        .tail_rev  (stage[0]),
        .end_a_in  (end_a_in),
        .end_b_in  (end_b_in),
        .start_hit (start_hit),
        .end_a_out (end_a_out),
        .end_a_oe  (end_a_oe),
        .end_b_out (end_b_out),
        .end_b_oe  (end_b_oe)
    );

    gate_scan_shifter #(.N_OUT(N_OUT)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir       (dir),
        .start_hit (start_hit),
        .stage     (stage)
    );

    gate_scan_override #(.N_OUT(N_OUT)) u_force (
        .stage     (stage),
        .blank_en  (blank_en),
        .blank_pol (blank_pol),
        .flood_en  (flood_en),
        .flood_pol (flood_pol),
        .scan_o    (scan_o)
    );

endmodule

// File: rtl/gate_scan_chk.sv
// Module: gate_scan_chk
// Port-level properties for gate_scan_core, attached through bind.
// Assumes: inputs change away from both clock edges.
module gate_scan_chk #(
    parameter int N_OUT = 240
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dir_fwd,
    input logic             start_pol,
    input logic             blank_en,
    input logic             blank_pol,
    input logic             flood_en,
    input logic             flood_pol,
    input logic             end_a_out,
    input logic             end_a_oe,
    input logic             end_b_out,
    input logic             end_b_oe,
    input logic [N_OUT-1:0] scan_o
);

    localparam int LAST = N_OUT - 1;

    logic blank_on;
    logic flood_on;
    logic quiet;

    // Override state as seen from the pins.
    always_comb begin
        blank_on = (blank_en == blank_pol);
        flood_on = (flood_en == flood_pol);
        quiet    = !blank_on && !flood_on;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && quiet) |-> (scan_o == '0)); // R1

    AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dir_fwd) && quiet && $past(quiet))
        |-> (scan_o[LAST:1] == $past(scan_o[LAST-1:0]))); // R2

    AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(dir_fwd) && quiet && $past(quiet))
        |-> (scan_o[LAST-1:0] == $past(scan_o[LAST:1]))); // R3

    AST_CASC_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_fwd && quiet) |-> ((end_b_out == start_pol) == scan_o[LAST])); // R5

    AST_CASC_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_fwd && quiet) |-> ((end_a_out == start_pol) == scan_o[0])); // R5

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        ({end_a_oe, end_b_oe} == {!dir_fwd, dir_fwd})); // R6

    AST_BLANK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_on && !flood_on) |-> (scan_o == '0)); // R7

    AST_FLOOD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (flood_on && !blank_on) |-> (scan_o == '1)); // R8

    AST_BLANK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (flood_on && blank_on) |-> (scan_o == '0)); // R10

endmodule

bind gate_scan_core gate_scan_chk #(.N_OUT(N_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_fwd   (dir_fwd),
    .start_pol (start_pol),
    .blank_en  (blank_en),
    .blank_pol (blank_pol),
    .flood_en  (flood_en),
    .flood_pol (flood_pol),
    .end_a_out (end_a_out),
    .end_a_oe  (end_a_oe),
    .end_b_out (end_b_out),
    .end_b_oe  (end_b_oe),
    .scan_o    (scan_o)
);

// File: tb/sim_gate_scan_core.sv
// Bench: a queue of pulse positions serves as the reference. It is
// advanced on every rising edge and compared after every falling edge.
module sim_gate_scan_core;

    localparam int N = 240;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, dir_fwd, start_pol;
    logic blank_en, blank_pol, flood_en, flood_pol;
    logic pin_a, pin_b;
    logic a_out, a_oe, b_out, b_oe;
    logic [N-1:0] scan_o;

    int checks = 0;
    int errors = 0;
    int pos_q[$];
    bit done = 1'b0;

    gate_scan_core #(.N_OUT(N)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_fwd   (dir_fwd),
        .start_pol (start_pol),
        .blank_en  (blank_en),
        .blank_pol (blank_pol),
        .flood_en  (flood_en),
        .flood_pol (flood_pol),
        .end_a_in  (pin_a),
        .end_a_out (a_out),
        .end_a_oe  (a_oe),
        .end_b_in  (pin_b),
        .end_b_out (b_out),
        .end_b_oe  (b_oe),
        .scan_o    (scan_o)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] model_bits();
        logic [N-1:0] v = '0;
        foreach (pos_q[k]) v[pos_q[k]] = 1'b1;
        return v;
    endfunction

    // Reference: move each pulse one place, drop exits, add new starts.
    always @(posedge clk) begin
        int nq[$];
        int np;
        if (!rst_n) begin
            pos_q = {};
        end else begin
            nq = {};
            foreach (pos_q[k]) begin
                np = dir_fwd ? pos_q[k] + 1 : pos_q[k] - 1;
                if (np >= 0 && np < N) nq.push_back(np);
            end
            if (dir_fwd && pin_a == start_pol)  nq.push_back(0);
            if (!dir_fwd && pin_b == start_pol) nq.push_back(N - 1);
            pos_q = nq;
        end
    end

    // Full comparison after every falling edge.
    always @(negedge clk) begin
        logic [N-1:0] m;
        logic [N-1:0] e;
        logic tail;
        string tag;
        #3;
        if (!done) begin
            m = model_bits();
            if (blank_en == blank_pol && flood_en == flood_pol) begin e = '0; tag = "R10"; end
            else if (blank_en == blank_pol) begin e = '0; tag = "R7"; end
            else if (flood_en == flood_pol) begin e = '1; tag = "R8"; end
            else begin e = m; tag = dir_fwd ? "R2" : "R3"; end
            chk(tag, scan_o, e);
            chk("R6", {{(N-2){1'b0}}, a_oe, b_oe}, {{(N-2){1'b0}}, !dir_fwd, dir_fwd});
            tail = dir_fwd ? m[N-1] : m[0];
            chk("R5", {{(N-1){1'b0}}, (dir_fwd ? b_out : a_out)},
                {{(N-1){1'b0}}, (tail ? start_pol : !start_pol)});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // One-cycle start pulse on the listening pin.
    task automatic pulse();
        if (dir_fwd) pin_a = start_pol; else pin_b = start_pol;
        tick(1);
        pin_a = !start_pol;
        pin_b = !start_pol;
    endtask

    initial begin
        rst_n = 0; dir_fwd = 1; start_pol = 1;
        blank_en = 0; blank_pol = 1; flood_en = 0; flood_pol = 1;
        pin_a = 0; pin_b = 0;
        tick(3);
        rst_n = 1;
        chk("R1", scan_o, '0);
        chk("R1", {{(N-1){1'b0}}, b_out}, {{(N-1){1'b0}}, !start_pol});

        // forward, active high, single and double pulses
        pulse();
        chk("R2", scan_o, {{(N-1){1'b0}}, 1'b1});
        tick(250);
        pulse(); tick(3); pulse();
        tick(250);

        // active-low start pulse
        start_pol = 0; pin_a = 1; pin_b = 1;
        tick(2);
        pulse();
        chk("R4", scan_o, {{(N-1){1'b0}}, 1'b1});
        chk("R11", {{(N-1){1'b0}}, scan_o[0]}, {{(N-1){1'b0}}, 1'b1});
        tick(250);

        // reverse direction
        dir_fwd = 0;
        tick(1);
        pulse();
        chk("R3", scan_o, {1'b1, {(N-1){1'b0}}});
        tick(250);

        // overrides under a moving pulse
        pulse(); tick(10);
        blank_en = 1;
        #1 chk("R7", scan_o, '0);
        tick(3);
        blank_en = 0;
        #1 chk("R7", scan_o, model_bits());
        blank_pol = 0; blank_en = 1;
        #1 chk("R9", scan_o, model_bits());
        blank_en = 0;
        #1 chk("R9", scan_o, '0);
        tick(2);
        blank_en = 1;
        flood_pol = 0; flood_en = 1;
        tick(1);
        flood_en = 0;
        #1 chk("R8", scan_o, '1);
        chk("R9", scan_o, '1);
        tick(2);
        blank_en = 0;
        #1 chk("R10", scan_o, '0);
        tick(2);
        blank_en = 1; flood_en = 1;
        #1 chk("R8", scan_o, model_bits());

        // direction reversal with a pulse mid-row
        tick(20);
        dir_fwd = 1;
        tick(250);

        // reset while pulses are in flight
        pulse(); tick(5);
        rst_n = 0;
        tick(2);
        rst_n = 1;
        chk("R1", scan_o, '0);
        tick(5);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule